// File: doc/BRIEF.md
# Serial Management Master (Clause 22)

This block drives the two-wire management bus used to configure Ethernet PHYs. Software programs a clock divisor and an enable bit, loads the data for a write, then issues one control word holding the PHY address, the register address, the operation and a start bit. The block sends the whole frame on the management clock and data lines, controls the data-line tristate, captures the 16 result bits of a read, and shows a ready flag while it is idle.

The register interface is a simple one-cycle write port plus a read port whose data is registered, so it appears one clock after the address. Word offsets: 0 = configuration, 1 = control/status, 2 = write data, 3 = read data.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, ready is high, the configuration word reads 29 (divisor 29, enable bit 6 clear), the read-data word reads 0, the clock output is low and the data line is released (output enable low).
- R2: While the enable bit (configuration bit 6) is set, the management clock changes level every (divisor + 1) system clocks, where the divisor is configuration bits 5:0.
- R3: While the enable bit is clear, the management clock stays low.
- R4: The control word holds the PHY address in bits 28:24, the register address in bits 20:16, read in bit 15 and write in bit 14. It reads back these fields, shows ready in bit 7, and bit 11 (start) always reads 0.
- R5: A write sends, MSB first and one bit per clock period: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 write-data bits. The data line changes on the falling edge of the clock.
- R6: A read sends the same header with opcode 10, releases the data line from the first turnaround bit to the end of the frame, samples the line on the rising clock edges of the 16 data bits, MSB first, and puts the result in the read-data word.
- R7: Ready reads low from the clock edge that accepts the start write. It stays low through the rising edge that samples the last data bit and returns high on the falling clock edge that ends that bit period.
- R8: A control write while ready is low has no effect: the control fields, the ongoing frame and the number of frames do not change.
- R9: If bits 15 and 14 are both set, the frame is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word offset |
| rd_data | output | 32 | Registered read data, valid one clock after rd_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
The hardest situation to reach is a second start write that arrives in the middle of a frame. The bench starts a transaction and waits until its bus model has counted some rising clock edges. It then writes a control word with a different PHY address. It checks that the readback still shows the first address, that the captured header is the first frame's, and that no second frame follows. The exact cycle when ready returns is also checked: ready is read once right after the last sampling edge, when it must still be low, and again after the next falling edge.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_LEN   = 32;
  localparam int HDR_LEN   = 46;  // preamble + start + opcode + two addresses
  localparam int DATA_POS  = 48;  // first data bit index in the frame
  localparam int FRAME_LEN = 64;

  localparam logic [1:0] OFF_CFG  = 2'd0;
  localparam logic [1:0] OFF_CTRL = 2'd1;
  localparam logic [1:0] OFF_WDAT = 2'd2;
  localparam logic [1:0] OFF_RDAT = 2'd3;

  localparam int CFG_EN_BIT   = 6;
  localparam int CTL_RD_BIT   = 15;
  localparam int CTL_WR_BIT   = 14;
  localparam int CTL_GO_BIT   = 11;
  localparam int CTL_RDY_BIT  = 7;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mgmt_mdc_div.sv
module mgmt_mdc_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term   = en && (cnt >= div);
  assign rise_p = term && !mdc;
  assign fall_p = term && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r3_mdc_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
  a_r3_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(en));
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mgmt_req_t   req,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] C_TA   = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] C_SMP  = CNT_W'(DATA_POS + 1);

  logic [FRAME_LEN-1:0] sh, frame_w;
  logic [CNT_W-1:0]     cnt;
  logic                 is_rd;
  logic [15:0]          rx;

  always_comb begin
    frame_w = {{PRE_LEN{1'b1}}, 2'b01, (req.rd ? 2'b10 : 2'b01),
               req.phy, req.regad, 2'b10, req.wdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      is_rd   <= 1'b0;
      rx      <= '0;
      rdata   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        sh    <= frame_w;
        cnt   <= '0;
        is_rd <= req.rd;
      end
    end else if (fall_p) begin
      if (cnt == C_END) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b1;
        if (is_rd) rdata <= rx;
      end else begin
        mdio_o  <= sh[FRAME_LEN-1];
        sh      <= {sh[FRAME_LEN-2:0], 1'b0};
        cnt     <= cnt + 1'b1;
        mdio_oe <= !(is_rd && (cnt >= C_TA));
      end
    end else if (rise_p && is_rd && (cnt >= C_SMP)) begin
      rx <= {rx[14:0], mdio_i};
    end
  end

  a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  a_r6_read_tail_released: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && cnt > C_TA) |-> !mdio_oe);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_END);
  a_r5_data_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(fall_p)) |-> $stable(mdio_o));
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(29)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_en;
  logic [4:0]       c_phy, c_reg;
  logic             c_rd, c_wr;
  logic [15:0]      wdat;
  logic [15:0]      rdat;
  logic             busy, start;
  logic             rise_p, fall_p;
  mgmt_req_t        req;

  assign start     = wr_en && (wr_addr == OFF_CTRL) && wr_data[CTL_GO_BIT] && !busy;
  assign req.rd    = wr_data[CTL_RD_BIT];
  assign req.phy   = wr_data[28:24];
  assign req.regad = wr_data[20:16];
  assign req.wdata = wdat;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= DIV_RESET;
      cfg_en  <= 1'b0;
      c_phy   <= '0;
      c_reg   <= '0;
      c_rd    <= 1'b0;
      c_wr    <= 1'b0;
      wdat    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFF_CFG: begin
          cfg_div <= wr_data[DIV_W-1:0];
          cfg_en  <= wr_data[CFG_EN_BIT];
        end
        OFF_CTRL: if (!busy) begin
          c_phy <= wr_data[28:24];
          c_reg <= wr_data[20:16];
          c_rd  <= wr_data[CTL_RD_BIT];
          c_wr  <= wr_data[CTL_WR_BIT];
        end
        OFF_WDAT: wdat <= wr_data[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        OFF_CFG: begin
          rd_data[DIV_W-1:0]  <= cfg_div;
          rd_data[CFG_EN_BIT] <= cfg_en;
        end
        OFF_CTRL: begin
          rd_data[28:24]       <= c_phy;
          rd_data[20:16]       <= c_reg;
          rd_data[CTL_RD_BIT]  <= c_rd;
          rd_data[CTL_WR_BIT]  <= c_wr;
          rd_data[CTL_RDY_BIT] <= !busy;
        end
        OFF_WDAT: rd_data[15:0] <= wdat;
        default:  rd_data[15:0] <= rdat;
      endcase
    end
  end

  mgmt_mdc_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .en(cfg_en), .div(cfg_div),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
  );

  mgmt_frame_eng i_eng (
    .clk(clk), .rst(rst), .start(start), .req(req),
    .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdat)
  );

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_CTRL && wr_data[CTL_GO_BIT] && !busy) |=> busy);
  a_r8_fields_held_busy: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(c_phy) && $stable(c_reg));
endmodule

// File: tb/test_mgmt_serial_master.sv
module test_mgmt_serial_master;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_drv = 0, phy_val = 1, phy_rd = 0;
  logic [15:0] phy_data = 0;
  logic        armed = 0, started = 0;
  int          rcnt = 0;
  logic        bits [64];
  logic        oes  [64];
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  assign mdio_i = phy_drv ? phy_val : (mdio_oe ? mdio_o : 1'b1);

  mgmt_serial_master i_mgmt_serial_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bus model: PHY drives on falling edges, bits are logged on rising edges
  initial forever begin
    @(negedge mdc);
    if (armed && !started) started = 1;
    if (started && phy_rd && rcnt == 47) begin phy_drv = 1; phy_val = 0; end
    else if (started && phy_rd && rcnt >= 48 && rcnt < 64) begin
      phy_drv = 1; phy_val = phy_data[63 - rcnt];
    end else phy_drv = 0;
  end
  initial forever begin
    @(posedge mdc);
    if (started && rcnt < 64) begin
      bits[rcnt] = mdio_i; oes[rcnt] = mdio_oe; rcnt = rcnt + 1;
    end else if (started) rcnt = rcnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #1 d = rd_data;
  endtask

  function automatic logic [31:0] ctl(input logic rd, input logic wr,
                                      input logic [4:0] p, input logic [4:0] r);
    return {3'b0, p, 3'b0, r, rd, wr, 2'b0, 1'b1, 11'b0};
  endfunction

  // run one frame and check it against the expected bit pattern
  task automatic run_txn(input logic rd, input logic wr, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d, input logic [5:0] dv);
    logic [31:0] v;
    logic [45:0] exp_hdr, got_hdr;
    logic [17:0] got_tail;
    logic        any_oe;
    logic        eff_rd;
    eff_rd = rd;
    reg_wr(2'd0, {25'b0, 1'b1, dv});
    reg_wr(2'd2, {16'b0, d});
    phy_rd = eff_rd; phy_data = d; rcnt = 0; started = 0; armed = 0;
    reg_wr(2'd1, ctl(rd, wr, p, r));
    armed = 1;
    reg_rd(2'd1, v);
    check("R7 ready low after start", 32'(v[7]), 32'd0);
    wait (rcnt == 64);
    reg_rd(2'd1, v);
    check("R7 ready low at last sample edge", 32'(v[7]), 32'd0);
    @(negedge mdc);
    reg_rd(2'd1, v);
    check("R7 ready back after final fall", 32'(v[7]), 32'd1);
    armed = 0; started = 0; phy_drv = 0;
    exp_hdr = {32'hFFFF_FFFF, 2'b01, (eff_rd ? 2'b10 : 2'b01), p, r};
    for (int i = 0; i < 46; i++) got_hdr[45 - i] = bits[i];
    check(eff_rd ? "R6 read header" : "R5 write header", {18'b0, got_hdr[45:32]}, {18'b0, exp_hdr[45:32]});
    check(eff_rd ? "R6 read header low" : "R5 write header low", got_hdr[31:0], exp_hdr[31:0]);
    if (eff_rd) begin
      any_oe = 0;
      for (int i = 46; i < 64; i++) any_oe = any_oe | oes[i];
      check("R6 line released in TA and data", 32'(any_oe), 32'd0);
      reg_rd(2'd3, v);
      check("R6 read data captured", v, {16'b0, d});
    end else begin
      for (int i = 46; i < 64; i++) got_tail[63 - i] = bits[i];
      check("R5 turnaround and data", {14'b0, got_tail}, {14'b0, 2'b10, d});
    end
  endtask

  typedef struct packed {
    logic rd; logic [4:0] phy; logic [4:0] regad; logic [15:0] data; logic [5:0] dv;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{1'b0, 5'h01, 5'h00, 16'hA5C3, 6'd3},
    '{1'b1, 5'h1F, 5'h01, 16'h796D, 6'd1},
    '{1'b0, 5'h10, 5'h1F, 16'h0001, 6'd0},
    '{1'b1, 5'h00, 5'h11, 16'h8000, 6'd2},
    '{1'b1, 5'h15, 5'h0A, 16'h5AA5, 6'd4}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    realtime t1, t2;
    int toggles;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    reg_rd(2'd0, v); check("R1 config reset", v, 32'd29);
    reg_rd(2'd1, v); check("R1 control reset ready", v, 32'h0000_0080);
    reg_rd(2'd3, v); check("R1 read data reset", v, 32'd0);
    check("R1 mdc low", 32'(mdc), 32'd0);
    check("R1 line released", 32'(mdio_oe), 32'd0);

    // R2 clock half period
    reg_wr(2'd0, {25'b0, 1'b1, 6'd4});
    @(posedge mdc); t1 = $realtime;
    @(negedge mdc); t2 = $realtime;
    check("R2 half period div=4", 32'(int'((t2 - t1) / 10.0)), 32'd5);
    reg_wr(2'd0, {25'b0, 1'b1, 6'd1});
    @(posedge mdc); t1 = $realtime;
    @(negedge mdc); t2 = $realtime;
    check("R2 half period div=1", 32'(int'((t2 - t1) / 10.0)), 32'd2);

    // R3 enable clear holds mdc low
    reg_wr(2'd0, {25'b0, 1'b0, 6'd1});
    toggles = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (mdc !== 1'b0) toggles++;
    end
    check("R3 mdc idle while disabled", toggles, 32'd0);

    // table of frames
    foreach (VECS[k])
      run_txn(VECS[k].rd, !VECS[k].rd, VECS[k].phy, VECS[k].regad, VECS[k].data, VECS[k].dv);

    // R4 control readback, start bit reads 0
    reg_rd(2'd1, v);
    check("R4 control readback", v, {3'b0, 5'h15, 3'b0, 5'h0A, 1'b1, 1'b0, 2'b0, 1'b0, 3'b0, 1'b1, 7'b0});

    // R9 both opcode bits set gives a read
    run_txn(1'b1, 1'b1, 5'h06, 5'h02, 16'hC0DE, 6'd1);

    // R8 start while busy ignored
    reg_wr(2'd0, {25'b0, 1'b1, 6'd1});
    reg_wr(2'd2, 32'h0000_1234);
    phy_rd = 0; rcnt = 0; started = 0; armed = 0;
    reg_wr(2'd1, ctl(1'b0, 1'b1, 5'h03, 5'h04));
    armed = 1;
    wait (rcnt == 10);
    reg_wr(2'd1, ctl(1'b1, 1'b0, 5'h07, 5'h08));
    reg_rd(2'd1, v);
    check("R8 fields held while busy", {27'b0, v[28:24]}, 32'h3);
    wait (rcnt == 64);
    @(negedge mdc);
    armed = 0; started = 0;
    begin
      logic [4:0] gp;
      for (int i = 0; i < 5; i++) gp[4 - i] = bits[36 + i];
      check("R8 frame kept first PHY address", {27'b0, gp}, 32'h3);
    end
    toggles = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (mdio_oe) toggles++;
    end
    check("R8 no second frame", toggles, 32'd0);
    reg_rd(2'd1, v);
    check("R8 ready after single frame", 32'(v[7]), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule